// File: doc/BRIEF.md
# Microframe Interrupt Rate Limiter

This block sits between a controller's event sources and its interrupt line. Each source gives a one-cycle pulse. The pulse is held as a pending cause bit until software clears it. The interrupt line does not follow the events directly. It is released only at the end of a spacing interval. That interval is measured in 125 µs microframes, counted from a tick input supplied by the frame timer.

The spacing comes from an 8-bit threshold field in a command register. A threshold of T lets at most one interrupt through every T microframes. A small threshold lowers latency but raises the interrupt count. A threshold of zero turns spacing off, and the line follows the pending causes one cycle after an event. Once raised, the line stays high until software has cleared every pending cause. Software clears causes by writing ones to the status clear port.

Top module: `irq_rate_limiter`

## Requirements
- R1: After reset, `irq_o` is 0, `pending_o` is all zeros and the threshold is 8, so with events pending the first interrupt follows the 8th microframe tick.
- R2: An event pulse on `event_i[k]` sets `pending_o[k]` in the next cycle. This holds whether the line is high or the interval is running. Pulses on several bits merge by OR, and no pulse is lost.
- R3: A clear write (`sts_clr_i`=1) zeroes each pending bit whose `sts_clr_data_i` bit is 1 and leaves the others alone. If an event on the same bit arrives in the same cycle as its clear, the bit stays set.
- R4: With threshold T>0, an interval boundary falls on every T-th tick, counted from reset or from the last threshold write. If any cause is pending after that cycle's updates, `irq_o` rises in the next cycle.
- R5: Once high, `irq_o` stays high until all pending bits are zero. It falls in the cycle after the write that clears the last bit.
- R6: With threshold 0, `irq_o` is 1 in the cycle after any event, and it tracks whether any cause is pending.
- R7: A command write (`cmd_wr_i`=1) loads the threshold from `cmd_wdata_i[23:16]` and ignores all other bits. It restarts the interval counter at zero, so the next boundary is T ticks after the write.
- R8: With threshold 1, every tick is a boundary.
- R9: A boundary with no pending cause leaves `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick_i | input | 1 | One-cycle pulse per 125 µs microframe |
| event_i | input | N_CAUSE | Event pulses, one per cause |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | DATA_W | Command write data; threshold in bits 23:16 |
| sts_clr_i | input | 1 | Status clear strobe |
| sts_clr_data_i | input | N_CAUSE | Write-one-to-clear mask |
| irq_o | output | 1 | Interrupt request |
| pending_o | output | N_CAUSE | Pending cause bits |

## Verification
The bench builds the block with its defaults: four causes, a 32-bit command word, the threshold at bit 16 and a reset threshold of 8. These defaults put the reset spacing, a loaded spacing of 3, the single-tick case and immediate mode all within a few dozen cycles. A behavioural model is compared with the outputs on every clock. A deterministic mixed phase then overlaps events, clears, ticks and threshold reloads, including events and clears on the same bit in the same cycle.

// File: rtl/irq_rl_pkg.sv
package irq_rl_pkg;
    localparam int unsigned CMD_THR_LSB  = 16;
    localparam int unsigned THR_WIDTH    = 8;
    localparam int unsigned THR_AT_RESET = 8;
endpackage

// File: rtl/rl_interval_timer.sv
module rl_interval_timer #(
    parameter int unsigned THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             bound_o
);
    typedef struct packed {
        logic [THR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic bound_d;

    always_comb begin
        tmr_d   = tmr_q;
        bound_d = 1'b0;
        if (restart_i) begin
            tmr_d.cnt = '0;
        end else if (tick_i && (thr_i != '0)) begin
            if (tmr_q.cnt == (thr_i - THR_W'(1))) begin
                bound_d   = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + THR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign bound_o = bound_d;

    assert_cnt_below_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i != '0) |-> (tmr_q.cnt < thr_i));
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (tmr_q.cnt == '0));
    assert_imm_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == '0) |-> (tmr_q.cnt == '0));
endmodule

// File: rtl/rl_cause_latch.sv
module rl_cause_latch #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] pend_d_o,
    output logic [N-1:0] pend_q_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } cause_t;

    cause_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (clr_en_i) cs_d.pend = cs_d.pend & ~clr_mask_i;
        cs_d.pend = cs_d.pend | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign pend_d_o = cs_d.pend;
    assign pend_q_o = cs_q.pend;

    assert_evt_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((cs_q.pend & $past(evt_i)) == $past(evt_i)));
    assert_clr_applies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((cs_q.pend & $past(clr_mask_i & ~evt_i)) == '0));
endmodule

// File: rtl/irq_rate_limiter.sv
module irq_rate_limiter
    import irq_rl_pkg::*;
#(
    parameter int unsigned N_CAUSE = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned THR_W   = THR_WIDTH,
    parameter int unsigned THR_LSB = CMD_THR_LSB,
    parameter int unsigned THR_RST = THR_AT_RESET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               uframe_tick_i,
    input  logic [N_CAUSE-1:0] event_i,
    input  logic               cmd_wr_i,
    input  logic [DATA_W-1:0]  cmd_wdata_i,
    input  logic               sts_clr_i,
    input  logic [N_CAUSE-1:0] sts_clr_data_i,
    output logic               irq_o,
    output logic [N_CAUSE-1:0] pending_o
);
    localparam int unsigned THR_MSB = THR_LSB + THR_W - 1;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             irq;
    } top_t;

    top_t st_d, st_q;
    logic bound;
    logic [N_CAUSE-1:0] pend_d, pend_q;

    rl_cause_latch #(.N(N_CAUSE)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (event_i),
        .clr_en_i   (sts_clr_i),
        .clr_mask_i (sts_clr_data_i),
        .pend_d_o   (pend_d),
        .pend_q_o   (pend_q)
    );

    rl_interval_timer #(.THR_W(THR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (uframe_tick_i),
        .restart_i (cmd_wr_i),
        .thr_i     (st_q.thr),
        .bound_o   (bound)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_wr_i) st_d.thr = cmd_wdata_i[THR_MSB:THR_LSB];
        st_d.irq = (st_q.irq | bound | (st_q.thr == '0)) & (|pend_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.thr <= THR_W'(THR_RST);
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = st_q.irq;
    assign pending_o = pend_q;

    assert_irq_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (|pend_q));
    assert_rise_on_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.irq) && ($past(st_q.thr) != '0)) |-> $past(bound));
    assert_thr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_i |=> (st_q.thr == $past(cmd_wdata_i[THR_MSB:THR_LSB])));
endmodule

// File: tb/irq_rate_limiter_bench.sv
module irq_rate_limiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [N-1:0] evt = '0;
    logic cmd_wr = 1'b0;
    logic [31:0] cmd_data = '0;
    logic clr_en = 1'b0;
    logic [N-1:0] clr_data = '0;
    logic irq;
    logic [N-1:0] pend;

    int checks = 0;
    int fails = 0;
    string cur = "R1";

    int m_thr, m_cnt;
    logic [N-1:0] m_pend;
    bit m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_rate_limiter u_irq_rate_limiter (
        .clk(clk), .rst_n(rst_n), .uframe_tick_i(tick), .event_i(evt),
        .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_data), .sts_clr_i(clr_en),
        .sts_clr_data_i(clr_data), .irq_o(irq), .pending_o(pend)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_thr = 8; m_cnt = 0; m_pend = '0; m_irq = 0;
        end else begin
            int old_thr;
            bit bnd;
            logic [N-1:0] np;
            old_thr = m_thr;
            bnd = 0;
            np = m_pend;
            if (clr_en) np = np & ~clr_data;
            np = np | evt;
            if (cmd_wr) begin
                m_thr = int'(cmd_data[23:16]);
                m_cnt = 0;
            end else if (tick && old_thr != 0) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == old_thr) begin bnd = 1; m_cnt = 0; end
            end
            m_irq = (m_irq || bnd || old_thr == 0) && (np != '0);
            m_pend = np;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit tk, input logic [N-1:0] ev, input bit ce,
                       input logic [N-1:0] cm, input bit we, input logic [31:0] wd);
        tick = tk; evt = ev; clr_en = ce; clr_data = cm; cmd_wr = we; cmd_data = wd;
        @(posedge clk);
        @(negedge clk);
        tick = 0; evt = '0; clr_en = 0; clr_data = '0; cmd_wr = 0; cmd_data = '0;
        check(irq == m_irq, {cur, " irq model"}, int'(irq), int'(m_irq));
        check(pend == m_pend, {cur, " pending model"}, int'(pend), int'(m_pend));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        check(pend == '0, "R1 pending after reset", int'(pend), 0);

        // R4 / R1: default threshold 8
        cur = "R4";
        cyc(0, 4'b0001, 0, '0, 0, '0);
        for (int i = 1; i <= 8; i++) begin
            cyc(1, (i == 3) ? 4'b0100 : 4'b0000, 0, '0, 0, '0);
            if (i < 8) check(irq == 1'b0, "R1 no irq before 8th tick", int'(irq), 0);
            else       check(irq == 1'b1, "R4 irq after 8th tick", int'(irq), 1);
            idle(2);
        end
        cur = "R2";
        check(pend == 4'b0101, "R2 merged causes", int'(pend), 5);

        // R3 / R5 clearing
        cur = "R5";
        idle(3);
        check(irq == 1'b1, "R5 irq held", int'(irq), 1);
        cur = "R3";
        cyc(0, '0, 1, 4'b0001, 0, '0);
        check(pend == 4'b0100, "R3 partial clear", int'(pend), 4);
        check(irq == 1'b1, "R5 irq held with cause left", int'(irq), 1);
        cyc(0, 4'b0100, 1, 4'b0100, 0, '0);
        check(pend == 4'b0100, "R3 event beats clear", int'(pend), 4);
        cur = "R5";
        cyc(0, '0, 1, 4'b0100, 0, '0);
        check(irq == 1'b0, "R5 irq drops after last clear", int'(irq), 0);
        check(pend == '0, "R5 pending empty", int'(pend), 0);

        // R9: boundary with nothing pending
        cur = "R9";
        for (int i = 0; i < 8; i++) cyc(1, '0, 0, '0, 0, '0);
        check(irq == 1'b0, "R9 no irq on empty boundary", int'(irq), 0);

        // R7: threshold load, other bits ignored, restart
        cur = "R7";
        for (int i = 0; i < 3; i++) cyc(1, '0, 0, '0, 0, '0);
        cyc(0, '0, 0, '0, 1, 32'hA503_5AC3);
        cyc(0, 4'b0010, 0, '0, 0, '0);
        cyc(1, '0, 0, '0, 0, '0);
        cyc(1, '0, 0, '0, 0, '0);
        check(irq == 1'b0, "R7 no irq before 3rd tick after write", int'(irq), 0);
        cyc(1, '0, 0, '0, 0, '0);
        check(irq == 1'b1, "R7 irq on 3rd tick after write", int'(irq), 1);
        cyc(0, '0, 1, 4'b1111, 0, '0);

        // R8: threshold 1
        cur = "R8";
        cyc(0, '0, 0, '0, 1, 32'h0001_0000);
        cyc(0, 4'b1000, 0, '0, 0, '0);
        idle(2);
        check(irq == 1'b0, "R8 waits for tick", int'(irq), 0);
        cyc(1, '0, 0, '0, 0, '0);
        check(irq == 1'b1, "R8 irq on first tick", int'(irq), 1);
        cyc(0, '0, 1, 4'b1111, 0, '0);

        // R6: immediate mode
        cur = "R6";
        cyc(0, '0, 0, '0, 1, 32'hFF00_FFFF);
        cyc(0, 4'b0010, 0, '0, 0, '0);
        check(irq == 1'b1, "R6 immediate irq", int'(irq), 1);
        cyc(0, 4'b0001, 1, 4'b0010, 0, '0);
        check(irq == 1'b1 && pend == 4'b0001, "R6 tracks pending", int'(pend), 1);
        cyc(0, '0, 1, 4'b0001, 0, '0);
        check(irq == 1'b0, "R6 drops when empty", int'(irq), 0);

        // mixed traffic against model
        cur = "R2";
        for (int i = 0; i < 160; i++) begin
            bit we;
            logic [31:0] wd;
            we = (i % 37) == 5;
            wd = {8'h00, 8'((i / 37) % 4), 16'h0000};
            cyc((i % 3) == 0, 4'((i * 7) % 16) & {4{(i % 5) == 1}},
                (i % 11) == 4, 4'((i * 3) % 16), we, wd);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule